// File: doc/BRIEF.md
# Speculative Scratchpad/Cache Read Selector

This block is the per-side controller of a level-one memory port that can be served by a local scratchpad RAM or by a cache. To finish a read in one cycle it enables only one of the two RAMs speculatively, and it does so before the address decode has decided which RAM holds the data. Enabling one RAM instead of both saves power. The guess is the RAM that the previous access on the same side used. When the resolved target differs from the guess, the block stalls the requester. It then replays the read to the correct RAM, so the access costs three cycles in total.

Sequential beats are taken to stay in the RAM of the previous beat. They never cause a replay and they do not change the history. The instruction side and the data side each use their own instance, so each side keeps its own history. A wrapping counter reports how many replays have been taken.

Target encoding used throughout: `acc_tgt` = 1 selects the scratchpad and `acc_tgt` = 0 selects the cache.

Top module: `spec_ram_sel`

## Requirements
- R1: After reset the history holds cache, the replay counter is 0, no RAM enable is active and `acc_ready` is 1 while no access is presented. The first non-sequential access to the cache then completes in one cycle.
- R2: At most one of `spm_en` and `cache_en` is high in any cycle. In the first cycle of an access the enabled RAM is the one the history names (`spm_en` for history 1, `cache_en` for history 0).
- R3: A non-sequential access whose target equals the history has `acc_ready` high in its first cycle, so it completes in one cycle with no replay.
- R4: A non-sequential access whose target differs from the history takes exactly three cycles. `acc_ready` is low in the first two cycles. `replay` pulses for one cycle in the second cycle, and only the correct RAM is enabled in that cycle. `acc_ready` is high in the third cycle.
- R5: After a replay the history equals the new target. Loads that alternate between the scratchpad and the cache therefore pay the three-cycle penalty on every switch.
- R6: A sequential access (`acc_seq` = 1) completes in one cycle whatever its target. It enables the RAM the history names and leaves the history unchanged.
- R7: `replay_cnt` increases by one (modulo 2^CNT_W) in the cycle after each replay pulse and holds its value otherwise.
- R8: While `acc_valid` is low, neither RAM is enabled and neither the history nor the counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented |
| acc_seq | input | 1 | The access is a sequential beat |
| acc_tgt | input | 1 | Resolved target: 1 scratchpad, 0 cache |
| spm_en | output | 1 | Scratchpad read enable |
| cache_en | output | 1 | Cache read enable |
| acc_ready | output | 1 | The access completes at the next clock edge |
| replay | output | 1 | A replay read is issued this cycle |
| replay_cnt | output | CNT_W | Replays taken since reset, wrapping |

## Verification
The assertions assume that a requester whose access is stalled keeps `acc_valid`, `acc_seq` and `acc_tgt` unchanged until `acc_ready` is seen. They also assume that a stalled access is never a sequential beat, since only non-sequential accesses can mispredict. The bench drives each access at the falling edge and does not change it until it has observed `acc_ready` high and passed the following rising edge. It then deasserts `acc_valid`, so the stimulus always stays within these assumptions. Sequential beats are only ever issued as fresh accesses. They are never issued in place of a stalled one.

// File: rtl/spec_ram_sel.sv
module spec_ram_sel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_seq,
  input  logic             acc_tgt,
  output logic             spm_en,
  output logic             cache_en,
  output logic             acc_ready,
  output logic             replay,
  output logic [CNT_W-1:0] replay_cnt
);
  typedef enum logic [1:0] {ST_IDLE, ST_RPL, ST_FIN} st_t;

  st_t  st, st_nx;
  logic last_tgt;
  logic sel_tgt;
  logic sel_on;

  wire miss = acc_valid && !acc_seq && (acc_tgt != last_tgt);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (miss) st_nx = ST_RPL;
      ST_RPL:  st_nx = ST_FIN;
      ST_FIN:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign acc_ready = (st == ST_FIN) || (st == ST_IDLE && !miss);
  assign replay    = (st == ST_RPL);
  assign sel_on    = (st == ST_IDLE && acc_valid) || (st == ST_RPL);
  assign sel_tgt   = (st == ST_RPL) ? acc_tgt : last_tgt;
  assign spm_en    = sel_on &&  sel_tgt;
  assign cache_en  = sel_on && !sel_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      last_tgt   <= 1'b0;
      replay_cnt <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_RPL) begin
        last_tgt   <= acc_tgt;
        replay_cnt <= replay_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spec_ram_sel_chk.sv
module spec_ram_sel_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_seq,
  input logic             spm_en,
  input logic             cache_en,
  input logic             acc_ready,
  input logic             replay,
  input logic [CNT_W-1:0] replay_cnt
);
  p_one_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spm_en, cache_en}));

  p_stall_leads_replay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready && !replay) |=> replay);

  p_replay_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (acc_ready && !replay));

  p_replay_one_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> (spm_en ^ cache_en));

  p_seq_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_seq) |-> acc_ready);

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (replay_cnt == CNT_W'($past(replay_cnt) + 1'b1)));

  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !replay |=> $stable(replay_cnt));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !replay) |-> (!spm_en && !cache_en));
endmodule

bind spec_ram_sel spec_ram_sel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_seq(acc_seq),
  .spm_en(spm_en), .cache_en(cache_en), .acc_ready(acc_ready),
  .replay(replay), .replay_cnt(replay_cnt)
);

// File: tb/test_spec_ram_sel.sv
module test_spec_ram_sel;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int NVEC = 9;
  // {seq, tgt, cycles[1:0], first-cycle {spm_en,cache_en}}
  localparam logic [5:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'd1, 2'b01},
    {1'b0, 1'b1, 2'd3, 2'b01},
    {1'b0, 1'b1, 2'd1, 2'b10},
    {1'b1, 1'b0, 2'd1, 2'b10},
    {1'b0, 1'b1, 2'd1, 2'b10},
    {1'b0, 1'b0, 2'd3, 2'b10},
    {1'b0, 1'b1, 2'd3, 2'b01},
    {1'b0, 1'b0, 2'd3, 2'b10},
    {1'b0, 1'b0, 2'd1, 2'b01}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_seq = 1'b0, acc_tgt = 1'b0;
  logic spm_en, cache_en, acc_ready, replay;
  logic [CNT_W-1:0] replay_cnt;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_ram_sel #(.CNT_W(CNT_W)) i_spec_ram_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_seq(acc_seq),
    .acc_tgt(acc_tgt), .spm_en(spm_en), .cache_en(cache_en),
    .acc_ready(acc_ready), .replay(replay), .replay_cnt(replay_cnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_access(input logic s, input logic t, input int ecyc,
                           input logic [1:0] een, input string req);
    int cyc;
    logic [1:0] ren;
    bit saw;
    @(negedge clk);
    acc_valid = 1'b1; acc_seq = s; acc_tgt = t;
    #1;
    check({spm_en, cache_en} == een, "R2", "first-cycle enables", {spm_en, cache_en}, een);
    cyc = 1; saw = 1'b0; ren = 2'b00;
    while (!acc_ready && cyc < 8) begin
      @(posedge clk); #1;
      cyc++;
      if (replay) begin saw = 1'b1; ren = {spm_en, cache_en}; end
    end
    check(cyc == ecyc, req, "access cycles", cyc, ecyc);
    if (ecyc == 3) begin
      check(saw && ren == (t ? 2'b10 : 2'b01), "R4", "replay-cycle enables", ren, t ? 2 : 1);
    end
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_seq = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "R0", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    check(replay_cnt == 0, "R1", "counter after reset", replay_cnt, 0);
    check(!spm_en && !cache_en, "R1", "enables after reset", {spm_en, cache_en}, 0);
    check(acc_ready, "R1", "ready idle", acc_ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      do_access(VEC[i][5], VEC[i][4], int'(VEC[i][3:2]), VEC[i][1:0],
                VEC[i][5] ? "R6" : (VEC[i][3:2] == 2'd3 ? "R5" : "R3"));
    end
    check(replay_cnt == 4, "R7", "replays after table", replay_cnt, 4);

    // R8 idle cycles: no enables, counter steady
    repeat (3) begin
      @(negedge clk); #1;
      check(!spm_en && !cache_en, "R8", "idle enables", {spm_en, cache_en}, 0);
    end
    check(replay_cnt == 4, "R8", "counter held idle", replay_cnt, 4);

    // R6 sequential beat to scratchpad while history is cache: no switch
    do_access(1'b1, 1'b1, 1, 2'b01, "R6");
    do_access(1'b0, 1'b0, 1, 2'b01, "R6");

    // R7 wrap of the counter modulo 2^CNT_W
    for (int k = 0; k < 252; k++) begin
      do_access(1'b0, ~k[0], 3, k[0] ? 2'b10 : 2'b01, "R5");
    end
    #1;
    check(replay_cnt == 0, "R7", "counter wrap", replay_cnt, 0);

    // R1 reset restores cache history (history is cache now; move to scratchpad first)
    do_access(1'b0, 1'b1, 3, 2'b01, "R4");
    do_reset();
    #1;
    check(replay_cnt == 0, "R1", "counter cleared", replay_cnt, 0);
    do_access(1'b0, 1'b0, 1, 2'b01, "R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule